// File: doc/BRIEF.md
# Three-level page table walker

This block turns a 64-bit virtual address into a physical address for one access. Each access is described by a required-access mask (read, write, execute) and a privilege mode (kernel or user). The first step screens the address. An address that is not properly sign-extended is refused. An address that falls in the direct-mapped kernel window is translated at once, with no memory traffic. Every other address is resolved by walking three levels of page tables in memory, starting from a table base supplied with the request.

Table entries are read one at a time over a request/response read port that returns 64-bit words. The walker keeps at most one read outstanding. For each translation it produces a one-cycle completion pulse. The pulse carries either the physical address with the granted permissions, or a fault flag with a fault code. Caching of finished translations and the memory behind the read port sit outside the block.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no translation is in progress. Each accepted request produces exactly one `done` pulse, which lasts one cycle.
- R2: Implemented virtual address bits are 42:0. If bits 63:43 are not all equal to bit 63, the result is an access violation (code 0) and no table entry is read.
- R3: An address with bit 63 set and bits 42:41 equal to 2'b10 is a kernel window address. In kernel mode it succeeds with no table read, with permissions 3'b111 and physical address {20'b0, va[40], 3'b0, va[39:0]}. In user mode it is an access violation.
- R4: The three 10-bit table indices are va[42:33], va[32:23] and va[22:13], in that order. Each entry is read from base + index*8. The first base is `table_base`. Each later base is entry[63:32] << 13.
- R5: At the first and second levels, an entry with bit 0 (valid) clear ends the walk with translation-not-valid (code 1). An entry with bit 8 (kernel read enable) clear ends the walk with an access violation (code 0).
- R6: At the third level, an entry with bit 0 clear gives code 1. Read permission is taken from bit 8 in kernel mode and bit 9 in user mode, and it also grants execute. Write permission is taken from bit 12 in kernel mode and bit 13 in user mode.
- R7: A non-zero required-access mask (bit 0 read, bit 1 write, bit 2 execute) that shares no bit with the granted permissions gives an access violation (code 0).
- R8: Granted permissions are then masked by the fault-on bits in entry bits 1 (read), 2 (write) and 3 (execute). If the masked set shares no bit with a non-zero required mask, the code is fault-on-execute (3) if execute is required, else fault-on-write (4) if write is required, else fault-on-read (2). An empty required mask always succeeds.
- R9: On success, `fault` is low. `pa` is entry[63:32] << 13 ORed with va[12:0], and `perm` is the masked permission set. On any fault, `pa` and `perm` are zero.
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`, and falls after the handshake until the response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_access | input | 3 | Required access mask: bit 0 read, bit 1 write, bit 2 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| table_base | input | 64 | Physical base of the first-level table |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation failed (valid with done) |
| fault_code | output | 3 | 0 access violation, 1 not valid, 2 fault-on-read, 3 fault-on-execute, 4 fault-on-write |
| pa | output | 64 | Physical address (valid with done) |
| perm | output | 3 | Granted permissions: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The walker is driven with addresses of four kinds:
- badly sign-extended addresses;
- kernel window addresses, with the relocated bit both set and clear;
- negative addresses just outside the window;
- ordinary addresses whose entries are built to stop the walk at each level.

The first three kinds show whether screening happens before any memory read, and whether the relocation is right. The fourth kind shows whether the walker stops at the correct level with the correct code. On leaf entries the bench sweeps modes, required masks and fault-on bits. This separates mode-shifted enable selection, the access-violation check, and the execute-over-write-over-read order of fault codes. A stalling ready pattern on the read port checks that each fetch address is held and issued in order.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    FLT_ACV = 3'd0,
    FLT_TNV = 3'd1,
    FLT_FOR = 3'd2,
    FLT_FOE = 3'd3,
    FLT_FOW = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_DONE
  } walk_state_e;

  // access / permission mask bit positions
  localparam int ACC_R = 0;
  localparam int ACC_W = 1;
  localparam int ACC_X = 2;

  // table entry bit positions
  localparam int PTE_V     = 0;
  localparam int PTE_FOR   = 1;
  localparam int PTE_FOW   = 2;
  localparam int PTE_FOE   = 3;
  localparam int PTE_KREAD = 8;
  localparam int PTE_UREAD = 9;
  localparam int PTE_KWR   = 12;
  localparam int PTE_UWR   = 13;

  // index of level lvl (0 = top) for a walk with pb page bits, lb index bits
  function automatic logic [63:0] table_index(input logic [63:0] va, input logic [1:0] lvl,
                                              input int pb, input int lb);
    int sh;
    case (lvl)
      2'd0:    sh = pb + 2 * lb;
      2'd1:    sh = pb + lb;
      default: sh = pb;
    endcase
    return (va >> sh) & ((64'd1 << lb) - 64'd1);
  endfunction

  function automatic logic [63:0] entry_addr(input logic [63:0] base, input logic [63:0] idx);
    return base + (idx << 3);
  endfunction

  function automatic logic [63:0] frame_of(input logic [63:0] pte, input int pb);
    return {32'd0, pte[63:32]} << pb;
  endfunction

endpackage

// File: rtl/pt_va_classify.sv
module pt_va_classify
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS = 43
) (
  input  logic [63:0] va,
  output logic        sign_bad,
  output logic        is_super,
  output logic [63:0] super_pa
);
  localparam logic [63:0] ALL_ONES = '1;
  localparam logic [63:0] HI_ONES  = ALL_ONES >> VA_BITS;

  logic [63:0] hi;

  always_comb begin
    hi       = va >> VA_BITS;
    sign_bad = va[63] ? (hi != HI_ONES) : (hi != 64'd0);
    is_super = !sign_bad && va[63] && (va[42:41] == 2'b10);
    super_pa = {20'd0, va[40], 3'd0, va[39:0]};
  end
endmodule

// File: rtl/pt_dir_check.sv
module pt_dir_check
  import pt_walker_pkg::*;
(
  input  logic   pte_valid,
  input  logic   pte_kread,
  output logic   ok,
  output fault_e code
);
  always_comb begin
    ok   = pte_valid && pte_kread;
    code = !pte_valid ? FLT_TNV : FLT_ACV;
  end
endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
  import pt_walker_pkg::*;
(
  input  logic       pte_valid,
  input  logic [2:0] fo_bits,
  input  logic [1:0] rd_en,
  input  logic [1:0] wr_en,
  input  logic       user,
  input  logic [2:0] need,
  output logic       ok,
  output fault_e     code,
  output logic [2:0] perm
);
  logic       rd, wr;
  logic [2:0] granted, masked;
  logic       acv, fo_hit;

  always_comb begin
    rd      = user ? rd_en[1] : rd_en[0];
    wr      = user ? wr_en[1] : wr_en[0];
    granted = {rd, wr, rd};
    acv     = (need != 3'd0) && ((granted & need) == 3'd0);
    masked  = granted & ~fo_bits;
    fo_hit  = (need != 3'd0) && ((masked & need) == 3'd0);
    perm    = masked;
    ok      = 1'b0;
    code    = FLT_ACV;
    if (!pte_valid)        code = FLT_TNV;
    else if (acv)          code = FLT_ACV;
    else if (fo_hit) begin
      if (need[ACC_X])      code = FLT_FOE;
      else if (need[ACC_W]) code = FLT_FOW;
      else                  code = FLT_FOR;
    end else               ok = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_va,
  input  logic [2:0]  req_access,
  input  logic        req_user,
  input  logic [63:0] table_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        fault,
  output logic [2:0]  fault_code,
  output logic [63:0] pa,
  output logic [2:0]  perm
);
  localparam logic [1:0]  LEAF_LVL = 2'd2;
  localparam logic [63:0] PG_MASK  = (64'd1 << PAGE_BITS) - 64'd1;

  walk_state_e state;
  logic [63:0] va_q, base_q;
  logic [2:0]  need_q;
  logic        user_q;
  logic [1:0]  lvl_q;
  logic        res_fault;
  fault_e      res_code;
  logic [63:0] res_pa;
  logic [2:0]  res_perm;

  // named internal events
  logic        accept, fast_path, rsp_dir, rsp_leaf;
  logic        cls_sign_bad, cls_super;
  logic [63:0] cls_super_pa;
  logic        dir_ok, leaf_ok;
  fault_e      dir_code, leaf_code;
  logic [2:0]  leaf_perm;

  pt_va_classify #(.VA_BITS(VA_BITS)) u_cls (
    .va      (req_va),
    .sign_bad(cls_sign_bad),
    .is_super(cls_super),
    .super_pa(cls_super_pa)
  );

  pt_dir_check u_dir (
    .pte_valid(mem_rsp_data[PTE_V]),
    .pte_kread(mem_rsp_data[PTE_KREAD]),
    .ok       (dir_ok),
    .code     (dir_code)
  );

  pt_leaf_check u_leaf (
    .pte_valid(mem_rsp_data[PTE_V]),
    .fo_bits  ({mem_rsp_data[PTE_FOE], mem_rsp_data[PTE_FOW], mem_rsp_data[PTE_FOR]}),
    .rd_en    ({mem_rsp_data[PTE_UREAD], mem_rsp_data[PTE_KREAD]}),
    .wr_en    ({mem_rsp_data[PTE_UWR], mem_rsp_data[PTE_KWR]}),
    .user     (user_q),
    .need     (need_q),
    .ok       (leaf_ok),
    .code     (leaf_code),
    .perm     (leaf_perm)
  );

  assign req_ready     = (state == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign fast_path     = cls_sign_bad || cls_super;
  assign rsp_dir       = (state == S_RSP) && mem_rsp_valid && (lvl_q != LEAF_LVL);
  assign rsp_leaf      = (state == S_RSP) && mem_rsp_valid && (lvl_q == LEAF_LVL);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = entry_addr(base_q, table_index(va_q, lvl_q, PAGE_BITS, IDX_BITS));
  assign done          = (state == S_DONE);
  assign fault         = res_fault;
  assign fault_code    = res_code;
  assign pa            = res_pa;
  assign perm          = res_perm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      need_q    <= '0;
      user_q    <= 1'b0;
      lvl_q     <= '0;
      res_fault <= 1'b0;
      res_code  <= FLT_ACV;
      res_pa    <= '0;
      res_perm  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          va_q      <= req_va;
          need_q    <= req_access;
          user_q    <= req_user;
          base_q    <= table_base;
          lvl_q     <= 2'd0;
          res_fault <= 1'b0;
          res_code  <= FLT_ACV;
          res_pa    <= '0;
          res_perm  <= '0;
          if (cls_sign_bad) begin
            res_fault <= 1'b1;
            state     <= S_DONE;
          end else if (cls_super) begin
            if (req_user) begin
              res_fault <= 1'b1;
            end else begin
              res_pa   <= cls_super_pa;
              res_perm <= 3'b111;
            end
            state <= S_DONE;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_RSP;
        S_RSP: begin
          if (rsp_dir) begin
            if (dir_ok) begin
              base_q <= frame_of(mem_rsp_data, PAGE_BITS);
              lvl_q  <= 2'(lvl_q + 2'd1);
              state  <= S_REQ;
            end else begin
              res_fault <= 1'b1;
              res_code  <= dir_code;
              state     <= S_DONE;
            end
          end else if (rsp_leaf) begin
            if (leaf_ok) begin
              res_pa   <= frame_of(mem_rsp_data, PAGE_BITS) | (va_q & PG_MASK);
              res_perm <= leaf_perm;
            end else begin
              res_fault <= 1'b1;
              res_code  <= leaf_code;
            end
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_screen_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fast_path) |=> (done && !mem_req_valid));

  assert_super_user_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_super && req_user) |=> (done && fault && fault_code == 3'd0));

  assert_leaf_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_leaf && leaf_ok) |-> (need_q == 3'd0 || (leaf_perm & need_q) != 3'd0));

  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code <= 3'd4));

  assert_fault_clears_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == 64'd0 && perm == 3'd0));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 13;
  localparam logic [63:0] BASE0 = 64'h0010_0000;
  localparam logic [63:0] V = 64'h1, FR = 64'h2, FW = 64'h4, FX = 64'h8;
  localparam logic [63:0] KR = 64'h100, UR = 64'h200, KW = 64'h1000, UW = 64'h2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [2:0]  req_access = '0;
  logic        req_user = 1'b0;
  logic [63:0] table_base = BASE0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [2:0]  fault_code, perm;
  logic [63:0] pa;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_addr_q [$];

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_access(req_access), .req_user(req_user), .table_base(table_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_code(fault_code), .pa(pa), .perm(perm)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // memory model: stalling ready, response two cycles after the handshake
  initial begin
    int cyc = 0;
    int cd = 0;
    logic [63:0] held;
    held = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(held);
        end
      end
      mem_req_ready = rst_n && ((cyc % 3) != 0);
      if (mem_req_valid && mem_req_ready) begin
        held = mem_req_addr;
        cd   = 2;
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R4", "unexpected table fetch", mem_req_addr, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_addr_q.pop_front();
          check(mem_req_addr == e, "R4", "fetch address", mem_req_addr, e);
        end
      end
    end
  end

  // behavioural reference for one translation
  task automatic model(input logic [63:0] va, input logic [2:0] acc, input logic user,
                       output logic xf, output logic [2:0] xc,
                       output logic [63:0] xpa, output logic [2:0] xperm);
    logic [63:0] hi, base, pte, idx, a;
    xf = 1; xc = 3'd0; xpa = 0; xperm = 0;
    hi = va >> 43;
    if (va[63] ? (hi != (64'hFFFF_FFFF_FFFF_FFFF >> 43)) : (hi != 0)) return;
    if (va[63] && ((va >> 41) & 64'd3) == 64'd2) begin
      if (user) return;
      xf = 0; xperm = 3'd7;
      xpa = (va & ((64'd1 << 40) - 1)) | (((va >> 40) & 64'd1) << 43);
      return;
    end
    base = BASE0;
    for (int lvl = 1; lvl <= 3; lvl++) begin
      idx = (va >> (PB + 10 * (3 - lvl))) & 64'd1023;
      a = base + idx * 8;
      exp_addr_q.push_back(a);
      pte = rd(a);
      if (!pte[0]) begin xc = 3'd1; return; end
      if (lvl < 3) begin
        if (!pte[8]) begin xc = 3'd0; return; end
        base = (pte >> 32) << PB;
      end else begin
        logic r, w;
        logic [2:0] prot;
        r = user ? pte[9] : pte[8];
        w = user ? pte[13] : pte[12];
        prot = (r ? 3'd5 : 3'd0) | (w ? 3'd2 : 3'd0);
        if (acc != 0 && (prot & acc) == 0) begin xc = 3'd0; return; end
        prot = prot & ~pte[3:1];
        if (acc != 0 && (prot & acc) == 0) begin
          xc = acc[2] ? 3'd3 : (acc[1] ? 3'd4 : 3'd2);
          return;
        end
        xf = 0; xperm = prot;
        xpa = ((pte >> 32) << PB) | (va & 64'h1FFF);
      end
    end
  endtask

  function automatic logic [63:0] mkva(input int i1, input int i2, input int i3, input int off);
    return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'(off);
  endfunction

  task automatic set_walk(input logic [63:0] va, input logic [63:0] l1,
                          input logic [63:0] l2, input logic [63:0] l3);
    logic [63:0] b;
    mem[BASE0 + ((va >> 33) & 64'd1023) * 8] = l1;
    b = (l1 >> 32) << PB;
    mem[b + ((va >> 23) & 64'd1023) * 8] = l2;
    b = (l2 >> 32) << PB;
    mem[b + ((va >> 13) & 64'd1023) * 8] = l3;
  endtask

  task automatic run(input string req, input logic [63:0] va, input logic [2:0] acc,
                     input logic user);
    logic xf; logic [2:0] xc, xperm; logic [63:0] xpa;
    int n;
    model(va, acc, user, xf, xc, xpa, xperm);
    check(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
    req_va = va; req_access = acc; req_user = user; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      check(req_ready == 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      n++;
    end
    if (!done) begin
      check(1'b0, "R1", "watchdog: no done", 64'd0, 64'd1);
      finish_run();
    end
    check(fault == xf, req, "fault flag", 64'(fault), 64'(xf));
    check(fault_code == xc || !xf, req, "fault code", 64'(fault_code), 64'(xc));
    check(pa == xpa, (xf ? "R9" : req), "physical address", pa, xpa);
    check(perm == xperm, (xf ? "R9" : req), "permissions", 64'(perm), 64'(xperm));
    check(exp_addr_q.size() == 0, "R4", "missing table fetches", 64'(exp_addr_q.size()), 64'd0);
    exp_addr_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R1", "done longer than one cycle", 64'(done), 64'd0);
    check(req_ready == 1'b1, "R1", "ready after done", 64'(req_ready), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "R1", "global watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] l1, l2, va;
    l1 = (64'h200 << 32) | V | KR;
    l2 = (64'h300 << 32) | V | KR;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
    check(mem_req_valid == 1'b0, "R10", "reset fetch request", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);

    // R2: bad sign extension, both polarities
    run("R2", 64'h0000_1000_0000_0000, 3'b001, 1'b0);
    run("R2", 64'hFFFF_7000_0000_0000, 3'b001, 1'b0);
    // R3: kernel window with relocated bit set / clear, user refused
    run("R3", 64'hFFFF_FD12_3456_789A, 3'b001, 1'b0);
    run("R3", 64'hFFFF_FC00_0000_4000, 3'b010, 1'b0);
    run("R3", 64'hFFFF_FD00_0000_0000, 3'b001, 1'b1);
    // R3 boundary: negative address with bits 42:41 = 11 walks normally
    va = 64'hFFFF_FE00_0000_2000 | mkva(0, 5, 7, 0);
    set_walk(va, l1, l2, (64'hABCDE << 32) | V | KR);
    run("R3", va, 3'b001, 1'b0);
    // R4/R9: kernel read success
    va = mkva(3, 17, 900, 12'h345);
    set_walk(va, l1, l2, (64'hABCDE << 32) | V | KR | KW);
    run("R4", va, 3'b001, 1'b0);
    // R5: top level invalid, second level without kernel read
    va = mkva(4, 1, 1, 0);
    set_walk(va, (64'h200 << 32) | KR, l2, V | KR);
    run("R5", va, 3'b001, 1'b0);
    va = mkva(5, 2, 2, 8);
    set_walk(va, l1, (64'h301 << 32) | V, V | KR);
    run("R5", va, 3'b001, 1'b0);
    // R6: leaf invalid; mode-shifted enables
    va = mkva(6, 3, 3, 0);
    set_walk(va, l1, l2, (64'h5 << 32) | KR | KW);
    run("R6", va, 3'b001, 1'b0);
    va = mkva(7, 4, 4, 16);
    set_walk(va, l1, l2, (64'h55 << 32) | V | UR | UW);
    run("R6", va, 3'b010, 1'b1);
    run("R6", va, 3'b100, 1'b1);
    // R7: no overlap -> access violation (user write to read-only, kernel on user-only)
    va = mkva(8, 5, 5, 0);
    set_walk(va, l1, l2, (64'h66 << 32) | V | UR | KW);
    run("R7", va, 3'b010, 1'b1);
    run("R7", va, 3'b001, 1'b0);
    // R8: fault-on codes and priority
    va = mkva(9, 6, 6, 0);
    set_walk(va, l1, l2, (64'h77 << 32) | V | KR | KW | FW);
    run("R8", va, 3'b010, 1'b0);
    set_walk(va, l1, l2, (64'h77 << 32) | V | KR | KW | FX | FW);
    run("R8", va, 3'b110, 1'b0);
    set_walk(va, l1, l2, (64'h77 << 32) | V | KR | KW | FR | FW);
    run("R8", va, 3'b011, 1'b0);
    set_walk(va, l1, l2, (64'h77 << 32) | V | KR | FR);
    run("R8", va, 3'b001, 1'b0);
    set_walk(va, l1, l2, (64'h77 << 32) | V | KR | FX);
    run("R8", va, 3'b001, 1'b0);
    set_walk(va, l1, l2, (64'h77 << 32) | V);
    run("R8", va, 3'b000, 1'b0);
    // R10: back-to-back walks under the stalling read port
    for (int k = 0; k < 6; k++) begin
      va = mkva(10 + k, 20 + k, 300 + k, k * 8);
      set_walk(va, l1, l2, (64'(64'h1000 + k) << 32) | V | KR | KW | UR);
      run("R10", va, 3'(k % 8), k[0]);
    end
    finish_run();
  end
endmodule